// File: doc/BRIEF.md
# Selectable Early/Held Address Stage

This block sits between a processor core's address generator and the external memory bus. Every memory cycle the core presents the address of its next access, together with the cycle attributes: direction, a 2-bit access size, a lock flag, an opcode-fetch flag and a privilege flag. The stage drives that group onto the bus with one of two timings. In early mode the group appears right after the rising clock edge that comes before its memory cycle. This leaves the memory system the rest of the cycle for decoding, which suits DRAM controllers and buses that need a pipelined address. In held mode the group appears after the falling edge and stays fixed through the whole memory cycle, which is what SRAM and ROM expect.

The timing is chosen at run time. The `pipe_en` input selects the mode and may be changed only while the clock is low. During that phase both timings show the same value, so a change of mode causes no glitch on the outputs. A second mechanism is kept for older systems: a transparent latch on the early path, opened by `latch_en`. With `pipe_en` tied high and `latch_en` driven as the inverse of the clock, the latch gives the held timing. Only one of the two controls is used at a time, and the unused one is tied high.

Top module: `addr_phase_stage`

## Requirements
- R1: The five attribute outputs always come from the same core cycle as `bus_addr`. The attribute field sits below the address in the packed word {addr, write, size[1:0], lock, fetch, priv}.
- R2: With `pipe_en` high and `latch_en` high, the outputs carry, right after a rising clock edge, the address and attributes that were on the core inputs just before that edge.
- R3: With `pipe_en` low, the outputs change only after a falling edge. Through the following high phase they show the value that was captured at the rising edge before that falling edge.
- R4: During the low clock phase the outputs show the value captured at the last rising edge in every mode. A change of `pipe_en` made in that phase leaves the outputs unchanged.
- R5: With `pipe_en` high, a low `latch_en` freezes the outputs at the value the latch held when it closed. A high `latch_en` lets the value captured at the last rising edge through.
- R6: An active-low `rst_n` clears the outputs, the falling-edge register and the latch to zero at once. The outputs stay zero until the first rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; rising edge captures, falling edge holds |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_en | input | 1 | 1 selects early timing, 0 selects held timing; change only while clk is low |
| latch_en | input | 1 | Legacy transparent-latch enable; tie high when unused |
| nxt_addr | input | ADDR_W | Address of the core's next memory cycle |
| nxt_write | input | 1 | Direction of the next cycle (1 = write) |
| nxt_size | input | 2 | Access size of the next cycle |
| nxt_lock | input | 1 | Locked-access flag of the next cycle |
| nxt_fetch | input | 1 | Opcode-fetch flag of the next cycle |
| nxt_priv | input | 1 | Privileged-access flag of the next cycle |
| bus_addr | output | ADDR_W | External address bus |
| bus_write | output | 1 | External direction |
| bus_size | output | 2 | External access size |
| bus_lock | output | 1 | External lock flag |
| bus_fetch | output | 1 | External opcode-fetch flag |
| bus_priv | output | 1 | External privilege flag |

## Verification
The assertions rely on these input rules:
- The core inputs change only in the low phase, after the falling edge, and stay steady across the next rising edge.
- `pipe_en` changes only in the low phase.
- `latch_en` is high through the low phase, and when it is used it drops just before the rising edge.
- Reset is released in a low phase.

The stimulus follows all of these rules. Every cycle the bench drives new core values a short moment after the falling edge. It picks modes at random in runs, and it sometimes switches mode in the middle of the low phase. In the legacy mode it opens the latch at the falling edge and closes it a short margin ahead of the rising edge.

// File: rtl/addr_phase_pkg.sv
`timescale 1ns/1ps
package addr_phase_pkg;

   // Access-size field width; the remaining attribute bits are single flags.
   localparam int SIZE_W = 2;
   localparam int FLAG_N = 4;
   localparam int ATTR_W = SIZE_W + FLAG_N;

   // Attribute group in its packed order below the address.
   typedef struct packed {
      logic              write;
      logic [SIZE_W-1:0] size;
      logic              lock;
      logic              fetch;
      logic              priv;
   } cyc_attr_t;

endpackage

// File: rtl/aps_edge_reg.sv
`timescale 1ns/1ps
// Word register with asynchronous active-low clear; the capture edge is a parameter.
module aps_edge_reg #(
   parameter int WIDTH   = 38,
   parameter bit FALLING = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("aps_edge_reg: WIDTH must be at least 1");
      end

      if (FALLING) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end
   endgenerate

endmodule

// File: rtl/aps_legacy_latch.sv
`timescale 1ns/1ps
// Transparent latch on the early path; can be removed by a parameter.
module aps_legacy_latch #(
   parameter int WIDTH  = 38,
   parameter bit ENABLE = 1'b1
) (
   input  logic             rst_n,
   input  logic             le,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (ENABLE) begin : g_latch
         logic [WIDTH-1:0] hold;
         always_latch begin
            if (!rst_n)  hold <= '0;
            else if (le) hold <= d;
         end
         assign q = hold;
      end else begin : g_bypass
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/aps_phase_mux.sv
`timescale 1ns/1ps
// Selects the early or the held word for the bus.
module aps_phase_mux #(
   parameter int WIDTH = 38
) (
   input  logic             pipe_en,
   input  logic [WIDTH-1:0] early,
   input  logic [WIDTH-1:0] held,
   output logic [WIDTH-1:0] q
);

   always_comb begin
      if (pipe_en) q = early;
      else         q = held;
   end

endmodule

// File: rtl/addr_phase_stage.sv
`timescale 1ns/1ps
module addr_phase_stage
   import addr_phase_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit HAS_LEGACY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_en,
   input  logic              latch_en,
   input  logic [ADDR_W-1:0] nxt_addr,
   input  logic              nxt_write,
   input  logic [SIZE_W-1:0] nxt_size,
   input  logic              nxt_lock,
   input  logic              nxt_fetch,
   input  logic              nxt_priv,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_write,
   output logic [SIZE_W-1:0] bus_size,
   output logic              bus_lock,
   output logic              bus_fetch,
   output logic              bus_priv
);

   localparam int WORD_W = ADDR_W + ATTR_W;

   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr
         $error("addr_phase_stage: ADDR_W must lie in 8..64");
      end
   endgenerate

   cyc_attr_t        core_attr;
   cyc_attr_t        out_attr;
   logic [WORD_W-1:0] core_word;
   logic [WORD_W-1:0] early_word;
   logic [WORD_W-1:0] held_word;
   logic [WORD_W-1:0] pass_word;
   logic [WORD_W-1:0] out_word;

   assign core_attr = '{write: nxt_write, size: nxt_size, lock: nxt_lock,
                        fetch: nxt_fetch, priv: nxt_priv};
   assign core_word = {nxt_addr, core_attr};

   // Rising edge: capture the core's next-cycle group.
   aps_edge_reg #(.WIDTH(WORD_W), .FALLING(1'b0)) u_early (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (core_word),
      .q     (early_word)
   );

   // Falling edge: hold the captured group for the whole memory cycle.
   aps_edge_reg #(.WIDTH(WORD_W), .FALLING(1'b1)) u_held (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (early_word),
      .q     (held_word)
   );

   // Legacy transparent latch behind the early register.
   aps_legacy_latch #(.WIDTH(WORD_W), .ENABLE(HAS_LEGACY)) u_latch (
      .rst_n (rst_n),
      .le    (latch_en),
      .d     (early_word),
      .q     (pass_word)
   );

   aps_phase_mux #(.WIDTH(WORD_W)) u_mux (
      .pipe_en (pipe_en),
      .early   (pass_word),
      .held    (held_word),
      .q       (out_word)
   );

   assign bus_addr  = out_word[WORD_W-1:ATTR_W];
   assign out_attr  = out_word[ATTR_W-1:0];
   assign bus_write = out_attr.write;
   assign bus_size  = out_attr.size;
   assign bus_lock  = out_attr.lock;
   assign bus_fetch = out_attr.fetch;
   assign bus_priv  = out_attr.priv;

endmodule

// File: rtl/aps_checker.sv
`timescale 1ns/1ps
module aps_checker #(
   parameter int WORD_W = 38,
   parameter int ATTR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pipe_en,
   input logic              latch_en,
   input logic [WORD_W-1:0] nxt_word,
   input logic [WORD_W-1:0] bus_word,
   input logic [WORD_W-1:0] early_word,
   input logic [WORD_W-1:0] held_word
);

   // R1: in early mode the attribute field tracks the same core cycle as the address.
   p_attr_group_r1: assert property (@(negedge clk) disable iff (!rst_n)
      (pipe_en && latch_en) |-> bus_word[ATTR_W-1:0] == nxt_word[ATTR_W-1:0]);

   // R2: early mode shows the group captured at the preceding rising edge.
   p_early_addr_r2: assert property (@(negedge clk) disable iff (!rst_n)
      (pipe_en && latch_en) |-> bus_word[WORD_W-1:ATTR_W] == nxt_word[WORD_W-1:ATTR_W]);

   // R3: held mode shows, in the high phase, what was captured one edge earlier.
   p_held_cycle_r3: assert property (@(negedge clk) disable iff (!rst_n)
      (!pipe_en && $past(rst_n)) |-> bus_word == $past(nxt_word));

   // R4: at the end of every low phase both timing paths agree.
   p_low_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
      held_word == early_word);

   // R5: a closed legacy latch keeps the previous cycle's group in the high phase.
   p_latch_hold_r5: assert property (@(negedge clk) disable iff (!rst_n)
      (pipe_en && !latch_en && $past(rst_n)) |-> bus_word == $past(nxt_word));

endmodule

bind addr_phase_stage aps_checker #(.WORD_W(WORD_W), .ATTR_W(ATTR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pipe_en    (pipe_en),
   .latch_en   (latch_en),
   .nxt_word   (core_word),
   .bus_word   (out_word),
   .early_word (early_word),
   .held_word  (held_word)
);

// File: tb/addr_phase_stage_test.sv
`timescale 1ns/1ps
module addr_phase_stage_test;

   localparam int AW = 32;
   localparam int WW = AW + 6;
   localparam int M_EARLY = 0, M_HELD = 1, M_LEGACY = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pipe_en = 1'b1;
   logic          latch_en = 1'b1;
   logic [AW-1:0] nxt_addr = '0;
   logic          nxt_write = 1'b0;
   logic [1:0]    nxt_size = '0;
   logic          nxt_lock = 1'b0, nxt_fetch = 1'b0, nxt_priv = 1'b0;
   logic [AW-1:0] bus_addr;
   logic          bus_write;
   logic [1:0]    bus_size;
   logic          bus_lock, bus_fetch, bus_priv;
   logic [WW-1:0] obs;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [WW-1:0] cur_w = '0;   // model: value captured at last rising edge
   logic [WW-1:0] prev_w = '0;  // model: value captured one rising edge earlier
   logic [WW-1:0] drv_w = '0;

   always #2.5 clk = ~clk;      // 200 MHz

   addr_phase_stage #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .latch_en(latch_en),
      .nxt_addr(nxt_addr), .nxt_write(nxt_write), .nxt_size(nxt_size),
      .nxt_lock(nxt_lock), .nxt_fetch(nxt_fetch), .nxt_priv(nxt_priv),
      .bus_addr(bus_addr), .bus_write(bus_write), .bus_size(bus_size),
      .bus_lock(bus_lock), .bus_fetch(bus_fetch), .bus_priv(bus_priv));

   assign obs = {bus_addr, bus_write, bus_size, bus_lock, bus_fetch, bus_priv};

   function automatic logic [WW-1:0] rand_word();
      return {$urandom(), 6'($urandom())};
   endfunction

   task automatic drive(input logic [WW-1:0] w);
      drv_w = w;
      {nxt_addr, nxt_write, nxt_size, nxt_lock, nxt_fetch, nxt_priv} = w;
   endtask

   task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // Reset with clocks running, release in a low phase with core inputs at zero.
   task automatic do_reset();
      rst_n = 1'b0;
      drive(rand_word());
      #0.5;
      check("R6 immediate clear", obs, '0);
      repeat (3) @(negedge clk);
      check("R6 held in reset", obs, '0);
      @(negedge clk);
      latch_en = 1'b1;
      #0.5;
      pipe_en = 1'b1;
      drive('0);
      rst_n = 1'b1;
      #1.0;
      check("R6 zero after release", obs, '0);
      @(posedge clk);
      prev_w = '0;
      cur_w = '0;
      #1.0;
      check("R6 zero first cycle", obs, '0);
   endtask

   // One memory cycle: low phase first, then high phase.
   task automatic cycle(input int mode, input logic [WW-1:0] w);
      logic [WW-1:0] before_sw;
      logic [WW-1:0] exp;
      @(negedge clk);
      latch_en = 1'b1;
      #0.3;
      before_sw = obs;
      #0.2;
      pipe_en = (mode != M_HELD);
      drive(w);
      #1.0;
      check("R4 low phase value", obs, cur_w);
      check("R4 mode change glitch-free", obs, before_sw);
      #0.5;
      if (mode == M_LEGACY) latch_en = 1'b0;
      @(posedge clk);
      prev_w = cur_w;
      cur_w = drv_w;
      #1.0;
      exp = (mode == M_EARLY) ? cur_w : prev_w;
      case (mode)
         M_EARLY: begin
            check("R2 early after rising edge", obs, exp);
            check("R1 attributes with address", {{AW{1'b0}}, obs[5:0]}, {{AW{1'b0}}, exp[5:0]});
         end
         M_HELD:  check("R3 held through high phase", obs, exp);
         default: check("R5 latch closed holds", obs, exp);
      endcase
   endtask

   initial begin : watchdog
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd7321));
      do_reset();

      // Directed: extreme patterns in each mode.
      cycle(M_EARLY, '1);
      cycle(M_EARLY, '0);
      cycle(M_HELD, '1);
      cycle(M_HELD, {AW'(32'hA5A5_5A5A), 6'b101101});
      cycle(M_LEGACY, {AW'(32'h1234_5678), 6'b010010});
      cycle(M_LEGACY, '1);
      // Directed: alternate mode every cycle.
      for (int i = 0; i < 8; i++) cycle(i % 3, rand_word());
      for (int i = 0; i < 6; i++) cycle((i % 2) ? M_HELD : M_EARLY, rand_word());

      // Random runs of modes.
      for (int r = 0; r < 60; r++) begin
         int m;
         int len;
         m = int'($urandom_range(2, 0));
         len = int'($urandom_range(6, 1));
         for (int k = 0; k < len; k++) cycle(m, rand_word());
      end

      // Reset in the middle of a run, then more traffic.
      @(posedge clk);
      #1.0;
      do_reset();
      for (int i = 0; i < 40; i++) cycle(int'($urandom_range(2, 0)), rand_word());

      done = 1'b1;
      summary();
      $finish;
   end

endmodule